// File: doc/BRIEF.md
# Effective Address Generator

This unit forms the memory effective address of one instruction operand. It can add up to three terms: a base register value, an index register value shifted left by a scale code, and a displacement taken from the instruction. Each term can be switched off. With these switches the unit covers seven forms: displacement only, register indirect, base plus displacement, index plus displacement, base plus index plus displacement, base plus scaled index, and base plus scaled index plus displacement. The unit has a wide (32-bit) mode and a narrow (16-bit) mode. In each mode the displacement is either one byte or the full mode width. An instruction never takes both operands from memory, so one address per accepted request is enough.

Requests arrive on a valid/ready stream and results leave on a second valid/ready stream through a single register stage. A request is accepted in a cycle when `in_valid` and `in_ready` are both high. Its result is shown one cycle later with `out_valid` high. While `out_valid` is high and `out_ready` is low, the result stays unchanged and `in_ready` is low, so back-pressure passes upstream in the same cycle. When `out_ready` is high, the stage can deliver one result and accept a new request in the same cycle. The unit does no segment translation and no paging.

Top module: `ea_unit`

## Requirements
- R1: In wide mode (`mode_wide`=1), `out_ea` = base + (index << `scale`) + extended displacement, modulo 2^32. A term whose enable is low counts as zero. A `disp_size` of 0 means no displacement.
- R2: `disp_size`=1 selects a byte displacement. `disp[7:0]` is sign-extended to the address width before the addition.
- R3: `disp_size`=2 selects a full displacement: `disp[31:0]` in wide mode, `disp[15:0]` in narrow mode.
- R4: In narrow mode only bits 15:0 of base, index and displacement are used. The sum wraps modulo 2^16 and `out_ea[31:16]` is zero.
- R5: In narrow mode, an enabled index with a nonzero `scale` is illegal. It sets `out_err` and forces `out_ea` to zero.
- R6: In wide mode, an enabled index whose register number `idx_sel` equals 4 (the stack pointer) is illegal. It sets `out_err` and forces `out_ea` to zero.
- R7: A request with no term at all (no base, no index, `disp_size`=0) is illegal, and so is `disp_size`=3. Both set `out_err` and force `out_ea` to zero.
- R8: A request accepted in one cycle is shown with `out_valid` high in the next cycle.
- R9: While `out_valid`=1 and `out_ready`=0, `out_ea` and `out_err` hold and `in_ready` is 0. Otherwise `in_ready` is 1.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A request is offered |
| in_ready | output | 1 | The unit can take a request |
| mode_wide | input | 1 | 1 = 32-bit addressing, 0 = 16-bit addressing |
| base_en | input | 1 | The base term is used |
| base_val | input | 32 | Base register value |
| idx_en | input | 1 | The index term is used |
| idx_sel | input | 3 | Register number of the index |
| idx_val | input | 32 | Index register value |
| scale | input | 2 | Left shift applied to the index (x1, x2, x4, x8) |
| disp | input | 32 | Displacement field |
| disp_size | input | 2 | 0 none, 1 byte, 2 full, 3 illegal |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the result |
| out_ea | output | 32 | Effective address, zero on error |
| out_err | output | 1 | The request used an illegal combination |

## Verification
The hardest case to reach is a stalled result that stays unchanged while new requests keep arriving: the input side holds a request that cannot be accepted yet. The stimulus drops `out_ready` at random, so results sit in the register for several cycles, and it changes the offered request while `in_ready` is low. The model then shows that nothing was taken in that time. Wrap-around at both widths and the negative byte displacement are driven with directed values such as 0xFFFF plus a positive displacement and 0 minus one.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int ADDR_W   = 32;
  localparam int NARROW_W = 16;
  localparam int SEL_W    = 3;
  localparam logic [SEL_W-1:0] SP_CODE = 3'd4;

  typedef enum logic [1:0] {
    DSZ_NONE = 2'd0,
    DSZ_BYTE = 2'd1,
    DSZ_FULL = 2'd2,
    DSZ_BAD  = 2'd3
  } dsz_e;

  typedef struct packed {
    logic [ADDR_W-1:0] ea;
    logic              err;
  } ea_result_t;
endpackage

// File: rtl/ea_disp_ext.sv
module ea_disp_ext #(
  parameter int AW = 32,
  parameter int NW = 16
) (
  input  logic [AW-1:0] disp,
  input  logic [1:0]    size,
  input  logic          wide,
  output logic [AW-1:0] ext,
  output logic          bad
);
  import ea_pkg::*;

  logic [AW-1:0] byte_ext;
  logic [AW-1:0] narrow_ext;

  assign byte_ext   = {{(AW-8){disp[7]}}, disp[7:0]};
  assign narrow_ext = {{(AW-NW){disp[NW-1]}}, disp[NW-1:0]};

  always_comb begin
    ext = '0;
    bad = 1'b0;
    unique case (dsz_e'(size))
      DSZ_NONE: ext = '0;
      DSZ_BYTE: ext = byte_ext;
      DSZ_FULL: ext = wide ? disp : narrow_ext;
      DSZ_BAD:  bad = 1'b1;
      default:  bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/ea_idx_scale.sv
module ea_idx_scale #(
  parameter int AW    = 32,
  parameter int SEL_W = 3,
  parameter logic [SEL_W-1:0] SP_SEL = 3'd4
) (
  input  logic [AW-1:0]    idx,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  input  logic [1:0]       scale,
  input  logic             wide,
  output logic [AW-1:0]    scaled,
  output logic             bad_scale,
  output logic             bad_sel
);
  logic [AW-1:0] shifted;

  always_comb begin
    unique case (scale)
      2'd0: shifted = idx;
      2'd1: shifted = {idx[AW-2:0], 1'b0};
      2'd2: shifted = {idx[AW-3:0], 2'b0};
      default: shifted = {idx[AW-4:0], 3'b0};
    endcase
  end

  assign scaled    = en ? shifted : '0;
  assign bad_scale = en && !wide && (scale != 2'd0);
  assign bad_sel   = en && wide && (sel == SP_SEL);
endmodule

// File: rtl/ea_stage.sv
module ea_stage #(
  parameter int DW = 33
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  logic          vld_q;
  logic [DW-1:0] dat_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_valid && in_ready) begin
      vld_q <= 1'b1;
      dat_q <= in_data;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  // R8: accepted request shows up next cycle
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R9: stalled result is held
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R9: nothing is accepted while stalled
  a_r9_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int NW    = NARROW_W,
  parameter int RSW   = SEL_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic           mode_wide,
  input  logic           base_en,
  input  logic [AW-1:0]  base_val,
  input  logic           idx_en,
  input  logic [RSW-1:0] idx_sel,
  input  logic [AW-1:0]  idx_val,
  input  logic [1:0]     scale,
  input  logic [AW-1:0]  disp,
  input  logic [1:0]     disp_size,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [AW-1:0]  out_ea,
  output logic           out_err
);
  localparam int DW = AW + 1;

  logic [AW-1:0] disp_ext, idx_scaled, base_term, raw_sum, trimmed;
  logic          disp_bad, scale_bad, sel_bad, empty_req, any_err;
  logic [DW-1:0] stage_in, stage_out;

  ea_disp_ext #(.AW(AW), .NW(NW)) u_disp (
    .disp (disp),
    .size (disp_size),
    .wide (mode_wide),
    .ext  (disp_ext),
    .bad  (disp_bad)
  );

  ea_idx_scale #(.AW(AW), .SEL_W(RSW), .SP_SEL(SP_CODE)) u_idx (
    .idx       (idx_val),
    .en        (idx_en),
    .sel       (idx_sel),
    .scale     (scale),
    .wide      (mode_wide),
    .scaled    (idx_scaled),
    .bad_scale (scale_bad),
    .bad_sel   (sel_bad)
  );

  assign base_term = base_en ? base_val : '0;
  assign raw_sum   = base_term + idx_scaled + disp_ext;
  assign empty_req = !base_en && !idx_en && (disp_size == 2'd0);
  assign any_err   = disp_bad || scale_bad || sel_bad || empty_req;

  // narrow mode keeps the low NW bits only; upper bits forced to zero
  for (genvar b = 0; b < AW; b++) begin : g_trim
    if (b < NW) begin : g_low
      assign trimmed[b] = raw_sum[b];
    end else begin : g_high
      assign trimmed[b] = raw_sum[b] && mode_wide;
    end
  end

  assign stage_in = {any_err ? '0 : trimmed, any_err};

  ea_stage #(.DW(DW)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (stage_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (stage_out)
  );

  assign out_ea  = stage_out[DW-1:1];
  assign out_err = stage_out[0];

  // R4: narrow result never has upper bits set
  a_r4_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !mode_wide |=> out_ea[AW-1:NW] == '0);

  // R5: scaled index in narrow mode flagged
  a_r5_narrow_scale: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !mode_wide && idx_en && scale != 2'd0 |=> out_err);

  // R6: stack pointer as index in wide mode flagged
  a_r6_sp_index: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && mode_wide && idx_en && idx_sel == SP_CODE |=> out_err);

  // R7: an error result carries a zero address
  a_r7_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_ea == '0);
endmodule

// File: tb/ea_unit_test.sv
`timescale 1ns/100ps
module ea_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic        mode_wide = 1'b1, base_en = 1'b0, idx_en = 1'b0;
  logic [31:0] base_val = '0, idx_val = '0, disp = '0;
  logic [2:0]  idx_sel = '0;
  logic [1:0]  scale = '0, disp_size = '0;
  logic        out_valid, out_ready = 1'b1, out_err;
  logic [31:0] out_ea;

  typedef struct {
    logic [31:0] ea;
    logic        err;
    string       tag;
  } exp_t;

  exp_t q[$];
  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ea_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mode_wide(mode_wide), .base_en(base_en), .base_val(base_val),
    .idx_en(idx_en), .idx_sel(idx_sel), .idx_val(idx_val), .scale(scale),
    .disp(disp), .disp_size(disp_size), .out_valid(out_valid),
    .out_ready(out_ready), .out_ea(out_ea), .out_err(out_err)
  );

  function automatic exp_t model();
    exp_t e;
    longint unsigned b, i, d, s, m;
    e.err = 0; e.ea = 0;
    e.tag = mode_wide ? "R1" : "R4";
    if (disp_size == 2'd1) e.tag = {e.tag, "/R2"};
    if (disp_size == 2'd2) e.tag = {e.tag, "/R3"};
    if (disp_size == 2'd3 || (!base_en && !idx_en && disp_size == 2'd0)) begin
      e.err = 1; e.tag = "R7";
    end else if (!mode_wide && idx_en && scale != 0) begin
      e.err = 1; e.tag = "R5";
    end else if (mode_wide && idx_en && idx_sel == 3'd4) begin
      e.err = 1; e.tag = "R6";
    end
    if (e.err) return e;
    m = mode_wide ? 64'hFFFF_FFFF : 64'hFFFF;
    b = base_en ? (base_val & m) : 0;
    i = idx_en ? ((idx_val & m) << scale) : 0;
    if (disp_size == 2'd1) d = {{56{disp[7]}}, disp[7:0]};
    else if (disp_size == 2'd2) d = mode_wide ? {{32{disp[31]}}, disp} : {{48{disp[15]}}, disp[15:0]};
    else d = 0;
    s = (b + i + d) & m;
    e.ea = s[31:0];
    return e;
  endfunction

  task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock of the stream: outputs are compared at the falling edge, new drives applied,
  // handshakes predicted, then the rising edge commits them
  task automatic step(input bit v, input bit rdy);
    exp_t e;
    bit in_fire, out_fire;
    check(q.size() ? "R8/R9 occupancy" : "R8 idle", {32'd0, out_valid}, {32'd0, q.size() != 0});
    if (out_valid && q.size() != 0)
      check(q[0].tag, {out_ea, out_err}, {q[0].ea, q[0].err});
    in_valid = v; out_ready = rdy;
    #0.5;
    in_fire = in_valid && in_ready;
    out_fire = out_valid && out_ready;
    if (out_valid && !out_ready)
      check("R9 ready low", {32'd0, in_ready}, 33'd0);
    if (out_fire) void'(q.pop_front());
    if (in_fire) begin e = model(); q.push_back(e); end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic req(input bit w, input bit be, input logic [31:0] bv, input bit ie,
                     input logic [2:0] is, input logic [31:0] iv, input logic [1:0] sc,
                     input logic [31:0] dv, input logic [1:0] ds);
    mode_wide = w; base_en = be; base_val = bv; idx_en = ie; idx_sel = is;
    idx_val = iv; scale = sc; disp = dv; disp_size = ds;
    step(1, 1);
  endtask

  initial begin
    #(5.0 * 150000);
    $display("FAIL watchdog: actual hung expected finish");
    fails++;
    vectors++;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 out_valid", {32'd0, out_valid}, 33'd0);
    check("R10 in_ready", {32'd0, in_ready}, 33'd1);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 seven forms, wide mode
    req(1, 0, 0, 0, 0, 0, 0, 32'h1234_5678, 2);            // absolute
    req(1, 1, 32'h1000, 0, 0, 0, 0, 0, 0);                  // register indirect
    req(1, 1, 32'h1000, 0, 0, 0, 0, 32'h7F, 1);             // based
    req(1, 0, 0, 1, 3, 32'h40, 0, 32'h10, 1);               // indexed
    req(1, 1, 32'h1000, 1, 1, 32'h20, 0, 32'h100, 2);       // based indexed disp
    req(1, 1, 32'h1000, 1, 6, 32'h20, 3, 0, 0);             // based scaled
    req(1, 1, 32'h1000, 1, 7, 32'h20, 2, 32'hFFFF_FFF0, 2); // based scaled disp
    // R2 negative byte, R1 wrap
    req(1, 1, 32'h0, 0, 0, 0, 0, 32'h0000_00FF, 1);
    req(1, 1, 32'hFFFF_FFFF, 1, 0, 32'h2, 1, 32'h1, 1);
    // R4 narrow wrap, R3 narrow full disp
    req(0, 1, 32'hABCD_FFFF, 0, 0, 0, 0, 32'h0000_0002, 2);
    req(0, 1, 32'h0000_0010, 1, 4, 32'hFFFF_0005, 0, 32'h1234_8000, 2);
    req(0, 0, 0, 0, 0, 0, 0, 32'h80, 1);
    // R5 R6 R7 illegal forms
    req(0, 1, 32'h10, 1, 2, 32'h4, 1, 0, 0);
    req(1, 1, 32'h10, 1, 4, 32'h4, 0, 0, 0);
    req(1, 0, 0, 0, 0, 0, 0, 32'h55, 0);
    req(1, 1, 32'h10, 0, 0, 0, 0, 32'h55, 3);
    // R9 stall with a changing offered request
    req(1, 1, 32'h3000, 0, 0, 0, 0, 32'h4, 1);
    for (int k = 0; k < 4; k++) begin
      base_val = 32'h9000 + k;
      step(1, 0);
    end
    step(0, 1);
    step(0, 1);
    // random traffic with random stalls
    for (int n = 0; n < 3000; n++) begin
      mode_wide = $urandom_range(0, 1); base_en = $urandom_range(0, 1);
      idx_en = $urandom_range(0, 1); idx_sel = 3'($urandom_range(0, 7));
      scale = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'd0;
      if (mode_wide) scale = 2'($urandom_range(0, 3));
      base_val = $urandom; idx_val = $urandom; disp = $urandom;
      disp_size = ($urandom_range(0, 9) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
      step($urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0);
    end
    while (q.size() != 0) step(0, 1);
    step(0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule